// File: doc/BRIEF.md
# Zone Access Protection Checker

This block rules on whether one memory access, already translated by a matching page entry, may proceed. The entry's attribute byte names one of sixteen protection zones. A 32-bit zone control word holds a 2-bit policy code for each zone. The privilege state of the requester then decides whether that code opens the access, denies it, or defers to the entry's own execute and write permission bits. The result comes back as a grant flag, a fault class and the set of rights actually given.

The checker is purely combinational and holds no state. Every output follows its inputs within the same cycle, so a pipeline stage can place it directly behind the entry lookup. It sees no data stream, so its pins are plain control and status signals with no valid/ready handshake.

Top module: `zone_guard`

## Requirements
- R1: The zone number is attribute bits [7:4]. Attribute bits [3:0] have no effect on any output.
- R2: The 2-bit policy code of zone z sits at bits [31-2z : 30-2z] of the zone control word, so zone 0 uses bits [31:30] and zone 15 uses bits [1:0].
- R3: With policy code 0 and `user_mode_i`=1, every access is refused with fault code 1 (zone refusal).
- R4: Policy code 0 in supervisor mode, and policy code 1 in either mode, apply the entry permission check.
- R5: Policy code 2 applies the entry permission check in user mode. In supervisor mode it opens the access without a check.
- R6: Policy code 3 opens every access in both modes without a check.
- R7: Under the entry check, a fetch (`access_i`=2) with `ent_exec_i`=0 is refused with fault code 2.
- R8: Under the entry check, a write (`access_i`=1) with `ent_write_i`=0 is refused with fault code 3. A read (`access_i`=0) is always granted. Code 3 on `access_i` is handled as a read.
- R9: `rights_o` is {execute, write, read}. An opened access reports 3'b011. A checked and granted access reports {ent_exec_i, ent_write_i, 1}. A refused access reports 3'b000.
- R10: `grant_o` is 1 exactly when `fault_o` is 0, and all outputs settle in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| attr_i | input | 8 | Attribute byte of the matching entry; bits [7:4] select the zone |
| zpr_i | input | 32 | Zone control word, 2 bits per zone, zone 0 at the top |
| user_mode_i | input | 1 | 1 = user privilege, 0 = supervisor |
| access_i | input | 2 | 0 read, 1 write, 2 fetch, 3 handled as read |
| ent_exec_i | input | 1 | Entry grants execute |
| ent_write_i | input | 1 | Entry grants write |
| grant_o | output | 1 | Access allowed |
| fault_o | output | 2 | 0 none, 1 zone refusal, 2 execute violation, 3 write violation |
| rights_o | output | 3 | Rights given: {execute, write, read} |

## Verification
The bench builds the checker with its default parameters: sixteen zones, an 8-bit attribute with the zone number at bit 4, and therefore a 32-bit control word. This size lets one vector table reach every policy code in both privilege states for all three access kinds. A sweep over all sixteen zone numbers then places a refusing code at each field position in turn. That sweep exposes any slip in the offset arithmetic of the field selection, including at the top and bottom ends of the word.

// File: rtl/zone_guard_pkg.sv
package zone_guard_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    MODE_REFUSE = 2'd0,
    MODE_CHECK  = 2'd1,
    MODE_OPEN   = 2'd2
  } zone_mode_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_ZONE  = 2'd1,
    FLT_EXEC  = 2'd2,
    FLT_WRITE = 2'd3
  } fault_e;

  localparam logic [2:0] RIGHT_R = 3'b001;
  localparam logic [2:0] RIGHT_W = 3'b010;
  localparam logic [2:0] RIGHT_X = 3'b100;
endpackage

// File: rtl/zpr_field_pick.sv
module zpr_field_pick #(
  parameter int NUM_ZONES = 16,
  localparam int ZSEL_W = $clog2(NUM_ZONES),
  localparam int ZPR_W  = 2 * NUM_ZONES
) (
  input  logic [ZPR_W-1:0]  zpr_i,
  input  logic [ZSEL_W-1:0] zsel_i,
  output logic [1:0]        code_o
);
  logic [1:0] field_q [NUM_ZONES];

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_field
    assign field_q[z] = zpr_i[ZPR_W-2-2*z +: 2];
  end

  always_comb begin
    code_o = 2'b00;
    if (int'(zsel_i) < NUM_ZONES) code_o = field_q[zsel_i];
  end
endmodule

// File: rtl/zone_mode_decode.sv
module zone_mode_decode
  import zone_guard_pkg::*;
(
  input  logic [1:0] code_i,
  input  logic       user_i,
  output zone_mode_e mode_o
);
  always_comb begin
    unique case (code_i)
      2'd0:    mode_o = user_i ? MODE_REFUSE : MODE_CHECK;
      2'd1:    mode_o = MODE_CHECK;
      2'd2:    mode_o = user_i ? MODE_CHECK : MODE_OPEN;
      default: mode_o = MODE_OPEN;
    endcase
  end

  always_comb begin
    if (!$isunknown({code_i, user_i})) begin
      AST_OPEN_CODE3: assert (code_i != 2'd3 || mode_o == MODE_OPEN); // R6
      AST_USER_NO_OPEN2: assert (!(code_i == 2'd2 && user_i) || mode_o == MODE_CHECK); // R5
    end
  end
endmodule

// File: rtl/access_judge.sv
module access_judge
  import zone_guard_pkg::*;
(
  input  zone_mode_e mode_i,
  input  logic [1:0] access_i,
  input  logic       exec_i,
  input  logic       write_i,
  output logic       grant_o,
  output fault_e     fault_o,
  output logic [2:0] rights_o
);
  acc_kind_e kind;
  assign kind = acc_kind_e'(access_i);

  always_comb begin
    grant_o  = 1'b0;
    fault_o  = FLT_NONE;
    rights_o = 3'b000;
    case (mode_i)
      MODE_REFUSE: fault_o = FLT_ZONE;
      MODE_OPEN: begin
        grant_o  = 1'b1;
        rights_o = RIGHT_R | RIGHT_W;
      end
      default: begin
        if (kind == ACC_FETCH && !exec_i)      fault_o = FLT_EXEC;
        else if (kind == ACC_WRITE && !write_i) fault_o = FLT_WRITE;
        else begin
          grant_o  = 1'b1;
          rights_o = RIGHT_R | (exec_i ? RIGHT_X : 3'b0) | (write_i ? RIGHT_W : 3'b0);
        end
      end
    endcase
  end

  always_comb begin
    if (!$isunknown({mode_i, access_i, exec_i, write_i})) begin
      AST_FETCH_NEEDS_X: assert (!(grant_o && mode_i == MODE_CHECK && kind == ACC_FETCH) || exec_i); // R7
      AST_WRITE_NEEDS_W: assert (!(grant_o && mode_i == MODE_CHECK && kind == ACC_WRITE) || write_i); // R8
    end
  end
endmodule

// File: rtl/zone_guard.sv
module zone_guard
  import zone_guard_pkg::*;
#(
  parameter int NUM_ZONES = 16,
  parameter int ATTR_W    = 8,
  parameter int ZSEL_LSB  = 4,
  localparam int ZSEL_W   = $clog2(NUM_ZONES),
  localparam int ZPR_W    = 2 * NUM_ZONES
) (
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [ZPR_W-1:0]  zpr_i,
  input  logic              user_mode_i,
  input  logic [1:0]        access_i,
  input  logic              ent_exec_i,
  input  logic              ent_write_i,
  output logic              grant_o,
  output logic [1:0]        fault_o,
  output logic [2:0]        rights_o
);
  logic [ZSEL_W-1:0] zsel;
  logic [1:0]        code;
  zone_mode_e        mode;
  fault_e            fault;

  assign zsel = attr_i[ZSEL_LSB +: ZSEL_W];

  zpr_field_pick #(.NUM_ZONES(NUM_ZONES)) u_pick (
    .zpr_i (zpr_i),
    .zsel_i(zsel),
    .code_o(code)
  );

  zone_mode_decode u_mode (
    .code_i(code),
    .user_i(user_mode_i),
    .mode_o(mode)
  );

  access_judge u_judge (
    .mode_i  (mode),
    .access_i(access_i),
    .exec_i  (ent_exec_i),
    .write_i (ent_write_i),
    .grant_o (grant_o),
    .fault_o (fault),
    .rights_o(rights_o)
  );

  assign fault_o = fault;

  always_comb begin
    if (!$isunknown({attr_i, zpr_i, user_mode_i, access_i, ent_exec_i, ent_write_i})) begin
      AST_GRANT_IFF_CLEAN: assert (grant_o == (fault_o == 2'd0)); // R10
      AST_REFUSE_NO_RIGHTS: assert (grant_o || rights_o == 3'b000); // R9
      AST_USER_CODE0_REFUSE: assert (!(code == 2'd0 && user_mode_i) || fault_o == 2'd1); // R3
      AST_READ_UNDER_CHECK: assert (!(mode == MODE_CHECK && access_i == 2'd0) || grant_o); // R8
    end
  end
endmodule

// File: tb/sim_zone_guard.sv
module sim_zone_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  attr = '0;
  logic [31:0] zpr = '0;
  logic        user = 1'b0;
  logic [1:0]  acc = '0;
  logic        xb = 1'b0;
  logic        wb = 1'b0;
  logic        grant;
  logic [1:0]  fault;
  logic [2:0]  rights;

  int checks = 0;
  int errors = 0;

  zone_guard u0 (
    .attr_i(attr), .zpr_i(zpr), .user_mode_i(user), .access_i(acc),
    .ent_exec_i(xb), .ent_write_i(wb),
    .grant_o(grant), .fault_o(fault), .rights_o(rights)
  );

  // zone z holds code z%4
  localparam logic [31:0] ZA = 32'h1B1B1B1B;
  // {attr, zpr, user, access, x, w, exp_grant, exp_fault, exp_rights}
  localparam logic [50:0] VEC [NV] = '{
    {8'h00, ZA, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd1, 3'b000}, // R3
    {8'h00, ZA, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 3'b001}, // R4 R8
    {8'h00, ZA, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 2'd3, 3'b000}, // R4 R8
    {8'h10, ZA, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 2'd0, 3'b011}, // R4 R9
    {8'h10, ZA, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 2'd2, 3'b000}, // R4 R7
    {8'h10, ZA, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 2'd0, 3'b101}, // R7 R9
    {8'h20, ZA, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 3'b011}, // R5
    {8'h20, ZA, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 2'd3, 3'b000}, // R5 R8
    {8'h20, ZA, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 3'b011}, // R5
    {8'h20, ZA, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 2'd2, 3'b000}, // R5 R7
    {8'h30, ZA, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 3'b011}, // R6
    {8'h30, ZA, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 3'b011}, // R6
    {8'h3F, ZA, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 3'b011}, // R1
    {8'h0F, ZA, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 3'b000}, // R1
    {8'h60, ZA, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 3'b001}, // R5 R9
    {8'h40, ZA, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 2'd1, 3'b000}, // R3
    {8'h10, ZA, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, 3'b001}, // R8
    {8'h50, ZA, 1'b0, 2'd1, 1'b1, 1'b1, 1'b1, 2'd0, 3'b111}  // R4 R9
  };

  task automatic check(input string req, input logic g, input logic [1:0] f, input logic [2:0] r);
    checks++;
    if (grant !== g || fault !== f || rights !== r) begin
      errors++;
      $display("FAIL %s: got grant=%0b fault=%0d rights=%03b, expected grant=%0b fault=%0d rights=%03b",
               req, grant, fault, rights, g, f, r);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // all-zero inputs: zone 0 code 0, supervisor read -> checked read (R4, R10)
    check("R10", 1'b1, 2'd0, 3'b001);

    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      v = VEC[i];
      @(negedge clk);
      {attr, zpr, user, acc, xb, wb} = v[50:6];
      @(posedge clk); #1;
      check($sformatf("R10 vec%0d", i), v[5], v[4:3], v[2:0]);
    end

    // R2: refusing code at each zone position, open code elsewhere
    for (int z = 0; z < 16; z++) begin
      @(negedge clk);
      zpr  = 32'hFFFF_FFFF & ~(32'h3 << (30 - 2*z));
      attr = 8'(z << 4);
      user = 1'b1; acc = 2'd0; xb = 1'b0; wb = 1'b0;
      @(posedge clk); #1;
      check($sformatf("R2 zone%0d", z), 1'b0, 2'd1, 3'b000);
      // neighbouring zone must stay open
      attr = 8'(((z + 1) % 16) << 4);
      #1;
      check($sformatf("R2 neighbour of zone%0d", z), 1'b1, 2'd0, 3'b011);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule